// File: doc/BRIEF.md
# Processor-to-Local Clock Write Bridge

This block carries processor bus writes from the processor clock domain into a local clock domain. The two clocks run at about the same frequency, but their phase is unknown and drifts. On the processor side, the strobe, address and data are registered on the processor clock before any other logic uses them. An accepted write is then parked in a hold register. Only one request flag leaves the processor domain. The local side sees that flag through a synchronizer chain, copies the parked vector into its output registers, emits a one-cycle valid pulse and returns an acknowledge. The acknowledge crosses back through a second synchronizer chain.

The handshake is four-phase. The request stays high until the synchronized acknowledge is seen. The acknowledge stays high until the synchronized request is seen low. The hold register is never written while a transfer is in flight, so the local side only ever samples a vector that is stable. A write that arrives during that window is dropped and recorded in a sticky overrun flag. The synchronizer depth is a parameter, and each extra stage adds one cycle to each crossing.

Top module: `cdc_write_bridge`

## Requirements
- R1: Each domain has its own asynchronous active-low reset, whose release is synchronized to that domain's clock. While in reset and after it, busy, overrun and valid are low and the local address and data outputs are zero.
- R2: A rising edge of the write strobe while not busy is one accepted write. The strobe stays high for at least two processor cycles, and any longer high time is still one write. Each accepted write produces exactly one valid pulse. That pulse carries the address and data present in the first processor cycle the strobe was high. Writes arrive in issue order, with none lost and none duplicated.
- R3: The valid output is high for exactly one local clock cycle per delivered write.
- R4: With the strobe raised just after a processor clock edge, busy is high when sampled after the second following edge. Busy stays high until the handshake has fully returned to idle. While busy is high, the parked vector does not change, so later changes on the address and data inputs do not alter the delivered write.
- R5: A strobe rising edge while busy is high is dropped (no valid pulse) and sets overrun. Overrun stays set until the processor-side reset and is never set by writes that arrive while not busy.
- R6: The request stays high until the synchronized acknowledge is seen. The acknowledge rises only while the synchronized request is high and falls only while it is low. Every transfer completes, and busy returns low.
- R7: `SYNC_STAGES` (D, at least 1) sets the synchronizer depth in both directions. With clocks of nominally equal frequency, busy stays high for between 4D and 4D+5 processor cycles per write, so the window grows with D.
- R8: Between valid pulses, the local address and data outputs hold the last delivered write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src_i | input | 1 | Processor bus clock |
| src_rst_ni | input | 1 | Processor-side asynchronous reset, active low |
| src_wr_i | input | 1 | Write strobe, at least two processor cycles high |
| src_addr_i | input | ADDR_W | Write address |
| src_data_i | input | DATA_W | Write data |
| src_busy_o | output | 1 | Transfer in flight; new writes are dropped |
| src_overrun_o | output | 1 | Sticky flag for a dropped write |
| clk_dst_i | input | 1 | Local clock |
| dst_rst_ni | input | 1 | Local-side asynchronous reset, active low |
| dst_valid_o | output | 1 | One-cycle pulse per delivered write |
| dst_addr_o | output | ADDR_W | Delivered address |
| dst_data_o | output | DATA_W | Delivered data |

## Verification
The assertions check, on every cycle, the local properties of the block:
- the parked vector stays frozen while busy is high;
- the request and acknowledge follow four-phase ordering against their synchronized copies;
- valid is a single-cycle pulse, and it occurs only on the rise of the acknowledge;
- overrun never clears without a reset;
- the outputs hold between pulses.

Properties that span both clocks can only be shown by bench scenarios, run with drifting phase:
- the delivered sequence matches the issued writes, with no loss, duplication or reordering;
- a write during busy is dropped;
- the busy window grows from depth 1 to depth 3.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic [1:0] {
    SRC_IDLE  = 2'd0,
    SRC_REQ   = 2'd1,
    SRC_DRAIN = 2'd2
  } src_st_e;

  typedef enum logic {
    DST_IDLE = 1'b0,
    DST_ACK  = 1'b1
  } dst_st_e;
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  if (STAGES <= 1) begin : g_one
    logic r_q;
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) r_q <= 1'b0;
      else         r_q <= d_i;
    assign q_o = r_q;
  end else begin : g_chain
    logic [STAGES-1:0] r_q;
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) r_q <= '0;
      else         r_q <= {r_q[STAGES-2:0], d_i};
    assign q_o = r_q[STAGES-1];
  end
endmodule

// File: rtl/hb_rst_sync.sv
module hb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] r_q;

  // assert asynchronously, release on the local clock
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) r_q <= '0;
    else         r_q <= {r_q[STAGES-2:0], 1'b1};

  assign rst_no = r_q[STAGES-1];
endmodule

// File: rtl/hb_src.sv
module hb_src
  import hb_pkg::*;
#(
  parameter int VEC_W = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [VEC_W-1:0] vec_i,
  input  logic             ack_s_i,
  output logic             req_o,
  output logic             busy_o,
  output logic             overrun_o,
  output logic [VEC_W-1:0] hold_o
);
  logic             wr_q, wr_prev_q;
  logic [VEC_W-1:0] vec_q, hold_q;
  logic             ovr_q;
  logic             rise, accept;
  src_st_e          st_q, st_d;

  // bus inputs are registered before any use
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      wr_q      <= 1'b0;
      wr_prev_q <= 1'b0;
      vec_q     <= '0;
    end else begin
      wr_q      <= wr_i;
      wr_prev_q <= wr_q;
      vec_q     <= vec_i;
    end

  assign rise   = wr_q & ~wr_prev_q;
  assign accept = rise && (st_q == SRC_IDLE);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SRC_IDLE:  if (accept)   st_d = SRC_REQ;
      SRC_REQ:   if (ack_s_i)  st_d = SRC_DRAIN;
      SRC_DRAIN: if (!ack_s_i) st_d = SRC_IDLE;
      default:                 st_d = SRC_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      st_q   <= SRC_IDLE;
      hold_q <= '0;
      ovr_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (accept) hold_q <= vec_q;
      if (rise && (st_q != SRC_IDLE)) ovr_q <= 1'b1;
    end

  assign req_o     = (st_q == SRC_REQ);
  assign busy_o    = (st_q != SRC_IDLE);
  assign overrun_o = ovr_q;
  assign hold_o    = hold_q;
endmodule

// File: rtl/hb_dst.sv
module hb_dst
  import hb_pkg::*;
#(
  parameter int VEC_W = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_s_i,
  input  logic [VEC_W-1:0] hold_i,
  output logic             ack_o,
  output logic             valid_o,
  output logic [VEC_W-1:0] vec_o
);
  dst_st_e          st_q;
  logic             valid_q;
  logic [VEC_W-1:0] out_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      st_q    <= DST_IDLE;
      valid_q <= 1'b0;
      out_q   <= '0;
    end else begin
      valid_q <= 1'b0;
      unique case (st_q)
        DST_IDLE:
          if (req_s_i) begin
            // hold_i is frozen while req is up
            out_q   <= hold_i;
            valid_q <= 1'b1;
            st_q    <= DST_ACK;
          end
        DST_ACK:
          if (!req_s_i) st_q <= DST_IDLE;
        default: st_q <= DST_IDLE;
      endcase
    end

  assign ack_o   = (st_q == DST_ACK);
  assign valid_o = valid_q;
  assign vec_o   = out_q;
endmodule

// File: rtl/cdc_write_bridge.sv
module cdc_write_bridge #(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_src_i,
  input  logic              src_rst_ni,
  input  logic              src_wr_i,
  input  logic [ADDR_W-1:0] src_addr_i,
  input  logic [DATA_W-1:0] src_data_i,
  output logic              src_busy_o,
  output logic              src_overrun_o,
  input  logic              clk_dst_i,
  input  logic              dst_rst_ni,
  output logic              dst_valid_o,
  output logic [ADDR_W-1:0] dst_addr_o,
  output logic [DATA_W-1:0] dst_data_o
);
  localparam int VEC_W      = ADDR_W + DATA_W;
  localparam int RST_STAGES = 2;

  logic             src_rst_n, dst_rst_n;
  logic             req, req_s, ack, ack_s;
  logic [VEC_W-1:0] hold_vec, out_vec;

  hb_rst_sync #(.STAGES(RST_STAGES)) u_rst_src (
    .clk_i (clk_src_i),
    .rst_ni(src_rst_ni),
    .rst_no(src_rst_n)
  );

  hb_rst_sync #(.STAGES(RST_STAGES)) u_rst_dst (
    .clk_i (clk_dst_i),
    .rst_ni(dst_rst_ni),
    .rst_no(dst_rst_n)
  );

  hb_src #(.VEC_W(VEC_W)) u_src (
    .clk_i    (clk_src_i),
    .rst_ni   (src_rst_n),
    .wr_i     (src_wr_i),
    .vec_i    ({src_addr_i, src_data_i}),
    .ack_s_i  (ack_s),
    .req_o    (req),
    .busy_o   (src_busy_o),
    .overrun_o(src_overrun_o),
    .hold_o   (hold_vec)
  );

  hb_sync #(.STAGES(SYNC_STAGES)) u_sync_req (
    .clk_i (clk_dst_i),
    .rst_ni(dst_rst_n),
    .d_i   (req),
    .q_o   (req_s)
  );

  hb_sync #(.STAGES(SYNC_STAGES)) u_sync_ack (
    .clk_i (clk_src_i),
    .rst_ni(src_rst_n),
    .d_i   (ack),
    .q_o   (ack_s)
  );

  hb_dst #(.VEC_W(VEC_W)) u_dst (
    .clk_i  (clk_dst_i),
    .rst_ni (dst_rst_n),
    .req_s_i(req_s),
    .hold_i (hold_vec),
    .ack_o  (ack),
    .valid_o(dst_valid_o),
    .vec_o  (out_vec)
  );

  assign dst_addr_o = out_vec[VEC_W-1:DATA_W];
  assign dst_data_o = out_vec[DATA_W-1:0];
endmodule

// File: rtl/hb_bridge_chk.sv
module hb_bridge_chk #(
  parameter int VEC_W = 48
) (
  input logic             clk_src_i,
  input logic             clk_dst_i,
  input logic             src_rst_n,
  input logic             dst_rst_n,
  input logic             req,
  input logic             req_s,
  input logic             ack,
  input logic             ack_s,
  input logic             src_busy_o,
  input logic             src_overrun_o,
  input logic             dst_valid_o,
  input logic [VEC_W-1:0] hold_vec,
  input logic [VEC_W-1:0] out_vec
);
  AST_HOLD_FROZEN: assert property (@(posedge clk_src_i) disable iff (!src_rst_n)
    src_busy_o |=> $stable(hold_vec)); // R4
  AST_REQ_UNTIL_ACK: assert property (@(posedge clk_src_i) disable iff (!src_rst_n)
    (req && !ack_s) |=> req); // R6
  AST_REQ_RISE_CLEAN: assert property (@(posedge clk_src_i) disable iff (!src_rst_n)
    $rose(req) |-> !ack_s); // R6
  AST_OVERRUN_STICKY: assert property (@(posedge clk_src_i) disable iff (!src_rst_n)
    src_overrun_o |=> src_overrun_o); // R5
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk_dst_i) disable iff (!dst_rst_n)
    dst_valid_o |=> !dst_valid_o); // R3
  AST_VALID_ON_ACK: assert property (@(posedge clk_dst_i) disable iff (!dst_rst_n)
    dst_valid_o |-> (ack && !$past(ack))); // R2
  AST_ACK_RISE_REQ: assert property (@(posedge clk_dst_i) disable iff (!dst_rst_n)
    $rose(ack) |-> req_s); // R6
  AST_ACK_FALL_NOREQ: assert property (@(posedge clk_dst_i) disable iff (!dst_rst_n)
    $fell(ack) |-> !req_s); // R6
  AST_OUT_HELD: assert property (@(posedge clk_dst_i) disable iff (!dst_rst_n)
    !dst_valid_o |-> $stable(out_vec)); // R8
endmodule

bind cdc_write_bridge hb_bridge_chk #(.VEC_W(VEC_W)) u_chk (
  .clk_src_i    (clk_src_i),
  .clk_dst_i    (clk_dst_i),
  .src_rst_n    (src_rst_n),
  .dst_rst_n    (dst_rst_n),
  .req          (req),
  .req_s        (req_s),
  .ack          (ack),
  .ack_s        (ack_s),
  .src_busy_o   (src_busy_o),
  .src_overrun_o(src_overrun_o),
  .dst_valid_o  (dst_valid_o),
  .hold_vec     (hold_vec),
  .out_vec      ({dst_addr_o, dst_data_o})
);

// File: tb/sim_cdc_write_bridge.sv
`timescale 1ps/1ps
module sim_cdc_write_bridge;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int NI = 3; // index i has sync depth i+1

  logic clk_src = 1'b0;
  logic clk_dst = 1'b0;
  always #5000 clk_src = ~clk_src;
  always #5025 clk_dst = ~clk_dst; // small offset: phase drifts

  logic          src_rst_n, dst_rst_n, wr;
  logic [AW-1:0] addr;
  logic [DW-1:0] data;
  wire  [NI-1:0] busy, ovr, vld;
  wire  [AW-1:0] oaddr [NI];
  wire  [DW-1:0] odata [NI];

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit mon_on = 1'b0;
  logic [AW+DW-1:0] exp_q[$];
  int rd_idx [NI];
  int blen [NI];
  int bsum [NI];
  int bcnt [NI];
  bit prev_vld [NI];

  cdc_write_bridge #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(2)) u0 (
    .clk_src_i(clk_src), .src_rst_ni(src_rst_n), .src_wr_i(wr),
    .src_addr_i(addr), .src_data_i(data),
    .src_busy_o(busy[1]), .src_overrun_o(ovr[1]),
    .clk_dst_i(clk_dst), .dst_rst_ni(dst_rst_n),
    .dst_valid_o(vld[1]), .dst_addr_o(oaddr[1]), .dst_data_o(odata[1]));

  cdc_write_bridge #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(1)) u1 (
    .clk_src_i(clk_src), .src_rst_ni(src_rst_n), .src_wr_i(wr),
    .src_addr_i(addr), .src_data_i(data),
    .src_busy_o(busy[0]), .src_overrun_o(ovr[0]),
    .clk_dst_i(clk_dst), .dst_rst_ni(dst_rst_n),
    .dst_valid_o(vld[0]), .dst_addr_o(oaddr[0]), .dst_data_o(odata[0]));

  cdc_write_bridge #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(3)) u2 (
    .clk_src_i(clk_src), .src_rst_ni(src_rst_n), .src_wr_i(wr),
    .src_addr_i(addr), .src_data_i(data),
    .src_busy_o(busy[2]), .src_overrun_o(ovr[2]),
    .clk_dst_i(clk_dst), .dst_rst_ni(dst_rst_n),
    .dst_valid_o(vld[2]), .dst_addr_o(oaddr[2]), .dst_data_o(odata[2]));

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk_src) begin
    cyc++;
    if (cyc == 150000) begin
      check(1'b0, "R6", "watchdog expired", cyc, 0);
      finish_sim();
    end
  end

  // scoreboard on the local side
  always @(negedge clk_dst) begin
    if (mon_on) begin
      for (int i = 0; i < NI; i++) begin
        if (vld[i]) begin
          check(!prev_vld[i], "R3", $sformatf("valid wider than one cycle d%0d", i+1), 1, 0);
          if (rd_idx[i] < exp_q.size())
            check({oaddr[i], odata[i]} == exp_q[rd_idx[i]], "R2",
                  $sformatf("delivered write d%0d #%0d", i+1, rd_idx[i]),
                  {oaddr[i], odata[i]}, exp_q[rd_idx[i]]);
          else
            check(1'b0, "R2", $sformatf("extra pulse d%0d", i+1), {oaddr[i], odata[i]}, 0);
          rd_idx[i]++;
        end
        prev_vld[i] = vld[i];
      end
    end
  end

  // busy window length per write
  always @(negedge clk_src) begin
    for (int i = 0; i < NI; i++) begin
      if (busy[i]) blen[i]++;
      else if (blen[i] != 0) begin
        check(blen[i] >= 4*(i+1) && blen[i] <= 4*(i+1)+5, "R7",
              $sformatf("busy window d%0d", i+1), blen[i], 4*(i+1));
        bsum[i] += blen[i];
        bcnt[i]++;
        blen[i] = 0;
      end
    end
  end

  task automatic wait_idle();
    int n = 0;
    @(negedge clk_src);
    while (busy != '0 && n < 200) begin
      @(negedge clk_src);
      n++;
    end
    check(busy == '0, "R6", "handshake returns to idle", busy, 0);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input int extra);
    wait_idle();
    @(negedge clk_src);
    wr = 1'b1; addr = a; data = d;
    exp_q.push_back({a, d});
    @(negedge clk_src);
    @(negedge clk_src);
    check(busy == 3'b111, "R4", "busy after accept", busy, 3'b111);
    addr = AW'($urandom); // parked copy must be used
    data = $urandom;
    repeat (extra) @(negedge clk_src);
    wr = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < NI; i++) begin
      rd_idx[i] = 0; blen[i] = 0; bsum[i] = 0; bcnt[i] = 0; prev_vld[i] = 1'b0;
    end
    wr = 1'b0; addr = '0; data = '0;
    src_rst_n = 1'b0; dst_rst_n = 1'b0;
    repeat (3) @(negedge clk_src);
    check(busy == '0, "R1", "busy in reset", busy, 0);
    check(ovr == '0, "R1", "overrun in reset", ovr, 0);
    @(negedge clk_dst);
    check(vld == '0, "R1", "valid in reset", vld, 0);
    src_rst_n = 1'b1; dst_rst_n = 1'b1;
    mon_on = 1'b1;
    repeat (5) @(negedge clk_src);
    check(busy == '0 && ovr == '0, "R1", "idle after reset", {busy, ovr}, 0);
    check(oaddr[1] == '0 && odata[1] == '0, "R1", "outputs zero after reset",
          {oaddr[1], odata[1]}, 0);

    // corner patterns, then random writes and gaps
    do_write('0, '0, 0);
    do_write('1, '1, 2);
    do_write(16'hA5A5, 32'h5A5A_5A5A, 1);
    do_write(16'h5A5A, 32'hA5A5_A5A5, 0);
    for (int k = 0; k < 120; k++) begin
      do_write(AW'($urandom), $urandom, $urandom_range(0, 3));
      repeat ($urandom_range(0, 4)) @(negedge clk_src);
    end
    wait_idle();
    check(ovr == '0, "R5", "no overrun without collision", ovr, 0);

    // write during busy: dropped, overrun set
    @(negedge clk_src);
    wr = 1'b1; addr = 16'h1234; data = 32'hCAFE_0001;
    exp_q.push_back({16'h1234, 32'hCAFE_0001});
    @(negedge clk_src);
    @(negedge clk_src);
    check(busy == 3'b111, "R4", "busy before collision", busy, 3'b111);
    wr = 1'b0;
    @(negedge clk_src);
    wr = 1'b1; addr = 16'hDEAD; data = 32'hBEEF_0002;
    @(negedge clk_src);
    @(negedge clk_src);
    wr = 1'b0;
    check(ovr == 3'b111, "R5", "overrun on collision", ovr, 3'b111);
    wait_idle();
    repeat (5) @(negedge clk_src);
    check(ovr == 3'b111, "R5", "overrun sticky", ovr, 3'b111);

    // processor-side reset clears overrun
    src_rst_n = 1'b0;
    repeat (3) @(negedge clk_src);
    check(ovr == '0 && busy == '0, "R5", "overrun cleared by reset", {ovr, busy}, 0);
    src_rst_n = 1'b1;
    repeat (4) @(negedge clk_src);

    // local-side reset alone
    @(negedge clk_dst);
    dst_rst_n = 1'b0;
    repeat (3) @(negedge clk_dst);
    check(vld == '0 && oaddr[0] == '0 && odata[2] == '0, "R1", "local reset state",
          {vld, oaddr[0]}, 0);
    dst_rst_n = 1'b1;
    repeat (4) @(negedge clk_dst);
    do_write(16'h0F0F, 32'h1357_9BDF, 1);
    wait_idle();

    repeat (30) @(negedge clk_dst);
    for (int i = 0; i < NI; i++) begin
      check(rd_idx[i] == exp_q.size(), "R2", $sformatf("pulse count d%0d", i+1),
            rd_idx[i], exp_q.size());
      check({oaddr[i], odata[i]} == exp_q[exp_q.size()-1], "R8",
            $sformatf("outputs hold last write d%0d", i+1),
            {oaddr[i], odata[i]}, exp_q[exp_q.size()-1]);
    end
    check(bcnt[0] == bcnt[1] && bcnt[1] == bcnt[2], "R7", "equal window counts",
          bcnt[0], bcnt[2]);
    check(bsum[0] < bsum[1], "R7", "latency grows d1->d2", bsum[0], bsum[1]);
    check(bsum[1] < bsum[2], "R7", "latency grows d2->d3", bsum[1], bsum[2]);
    finish_sim();
  end
endmodule